// File: doc/BRIEF.md
# Rail Power-Good Reset Supervisor

This block watches the output rails of a multi-channel step-down regulator and drives one active-low reset line per rail. Each rail's line is pulled low until the rail has stayed above its upper comparator threshold for a programmed wait time. It is pulled low again at once when the rail drops below its lower comparator threshold. The analog comparators sit outside the block. Each channel gets two digital flags from them: one that says the rail is above the upper threshold, and one that says the rail is below the lower threshold. A shared 1 µs tick paces every wait.

Each channel is independent. Each one has its own enable, its own 2-bit wait selection and its own supervision-off bit. The output `drv_low` is meant to control an open-drain pull-down transistor. A 1 means "pull the reset line low" and a 0 means "let it float high". The two comparator thresholds differ, and this gives the release and the reassertion a hysteresis band.

Top module: `rsv_supervisor`

## Requirements
- R1: Coming out of reset, every channel whose supervision-off bit is clear has `drv_low` = 1.
- R2: While a channel is enabled but its above-upper flag stays 0, `drv_low` stays 1, however many ticks arrive.
- R3: Arming starts a wait. A channel arms on the first clock edge at which it is enabled, its above-upper flag is 1 and its below-lower flag is 0. `drv_low` falls to 0 on the clock edge that counts the N-th tick after arming, and no earlier. N is set by the channel's 2-bit select: code 00 gives DLY_SEL0 ticks (default 50000), 01 gives DLY_SEL1 (default 50), 10 gives DLY_SEL2 (default 100000) and 11 gives DLY_SEL3 (default 200000). Channel c uses select bits [2c+1:2c].
- R4: The select value is captured when the channel arms. Changing the select during a wait has no effect on the length of that wait.
- R5: A below-lower flag seen during a wait cancels the wait and sets `drv_low` to 1. The next arming counts the full N ticks again from zero.
- R6: Once released, a below-lower flag sets `drv_low` to 1 on the very next clock edge, with no tick needed.
- R7: Clearing a channel's enable sets `drv_low` to 1 on the next clock edge and discards any partial count. After the enable returns, the channel must arm again and wait the full N ticks.
- R8: While a channel's supervision-off bit is 1, its `drv_low` is 0 in the same cycle, whatever the comparator flags show. Clearing the bit makes `drv_low` 1 at once, and the channel then has to arm and wait the full N ticks again.
- R9: Channels are independent. A fault, enable or select change on one channel leaves the other channel's output unchanged.
- R10: The above-upper flag going back to 0 does not affect a channel whose below-lower flag is clear. A released channel stays released, and a wait in progress keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-cycle pulse every microsecond, shared by all channels |
| en | input | NUM_CH | Per-channel enable |
| above_rise | input | NUM_CH | Rail is above the upper (release) threshold |
| below_fall | input | NUM_CH | Rail is below the lower (fault) threshold |
| dly_sel | input | 2*NUM_CH | Per-channel wait select, 2 bits each |
| por_dis | input | NUM_CH | Per-channel supervision-off bit |
| drv_low | output | NUM_CH | 1 = pull that channel's reset line low |

## Verification
Each channel holds only a three-way state and a tick count, and `drv_low` shows that state directly. A stuck or skipped state therefore shows up as a wrong level on `drv_low` at the first edge after the stimulus that should have moved it. A count that is off by one shows up as a release one tick early or one tick late. A count that is not cleared on cancel or on enable loss shows up as a shortened second wait. For these reasons the tests use short wait values and place each tick themselves. This lets them sample the output on the exact edge before and after the expected release.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    // Per-channel supervisor state
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,   // reset driven, waiting for rail to arm
        ST_WAIT  = 2'd1,   // rail good, counting release ticks
        ST_GOOD  = 2'd2    // released
    } rsv_state_e;

    // Wait-select code values
    localparam logic [1:0] SEL_DEFAULT = 2'b00;
    localparam logic [1:0] SEL_SHORT   = 2'b01;
    localparam logic [1:0] SEL_LONG    = 2'b10;
    localparam logic [1:0] SEL_LONGEST = 2'b11;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/rsv_delay_lut.sv
module rsv_delay_lut #(
    parameter int unsigned DLY_SEL0 = 50000,
    parameter int unsigned DLY_SEL1 = 50,
    parameter int unsigned DLY_SEL2 = 100000,
    parameter int unsigned DLY_SEL3 = 200000,
    parameter int unsigned CNT_W    = 18
) (
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] ticks
);
    import rsv_pkg::*;

    always_comb begin
        unique case (sel)
            SEL_DEFAULT: ticks = CNT_W'(DLY_SEL0);
            SEL_SHORT:   ticks = CNT_W'(DLY_SEL1);
            SEL_LONG:    ticks = CNT_W'(DLY_SEL2);
            default:     ticks = CNT_W'(DLY_SEL3);
        endcase
    end

endmodule

// File: rtl/rsv_tick_counter.sv
module rsv_tick_counter #(
    parameter int unsigned CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] target,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   cnt_next;

    always_comb begin
        cnt_next = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
        expire   = inc && !clr && (cnt_next >= {1'b0, target});
        cnt_d    = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && !expire) begin
            cnt_d = cnt_next[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/rsv_channel.sv
module rsv_channel #(
    parameter int unsigned DLY_SEL0 = 50000,
    parameter int unsigned DLY_SEL1 = 50,
    parameter int unsigned DLY_SEL2 = 100000,
    parameter int unsigned DLY_SEL3 = 200000,
    parameter int unsigned CNT_W    = 18
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1us,
    input  logic       en,
    input  logic       above_rise,
    input  logic       below_fall,
    input  logic [1:0] dly_sel,
    input  logic       por_dis,
    output logic       drv_low
);
    import rsv_pkg::*;

    typedef struct packed {
        rsv_state_e       st;
        logic [CNT_W-1:0] tgt;
    } ch_regs_t;

    ch_regs_t         r_d, r_q;
    logic [CNT_W-1:0] sel_ticks;
    logic             cnt_clr, cnt_inc, cnt_expire;

    rsv_delay_lut #(
        .DLY_SEL0 (DLY_SEL0),
        .DLY_SEL1 (DLY_SEL1),
        .DLY_SEL2 (DLY_SEL2),
        .DLY_SEL3 (DLY_SEL3),
        .CNT_W    (CNT_W)
    ) lut_i (
        .sel   (dly_sel),
        .ticks (sel_ticks)
    );

    rsv_tick_counter #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .inc    (cnt_inc),
        .target (r_q.tgt),
        .expire (cnt_expire)
    );

    // Counter is cleared outside the wait state, so every wait starts at zero
    always_comb begin
        cnt_clr = (r_q.st != ST_WAIT) || !en || por_dis || below_fall;
        cnt_inc = (r_q.st == ST_WAIT) && tick_1us;
    end

    always_comb begin
        r_d = r_q;
        if (!en || por_dis) begin
            r_d.st = ST_HOLD;
        end else begin
            unique case (r_q.st)
                ST_HOLD: begin
                    if (above_rise && !below_fall) begin
                        r_d.st  = ST_WAIT;
                        r_d.tgt = sel_ticks;   // capture select at arming
                    end
                end
                ST_WAIT: begin
                    if (below_fall)      r_d.st = ST_HOLD;
                    else if (cnt_expire) r_d.st = ST_GOOD;
                end
                ST_GOOD: begin
                    if (below_fall) r_d.st = ST_HOLD;
                end
                default: r_d.st = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_HOLD;
            r_q.tgt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign drv_low = !por_dis && (r_q.st != ST_GOOD);

endmodule

// File: rtl/rsv_supervisor.sv
module rsv_supervisor #(
    parameter int unsigned NUM_CH   = 2,
    parameter int unsigned DLY_SEL0 = 50000,
    parameter int unsigned DLY_SEL1 = 50,
    parameter int unsigned DLY_SEL2 = 100000,
    parameter int unsigned DLY_SEL3 = 200000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_1us,
    input  logic [NUM_CH-1:0]     en,
    input  logic [NUM_CH-1:0]     above_rise,
    input  logic [NUM_CH-1:0]     below_fall,
    input  logic [2*NUM_CH-1:0]   dly_sel,
    input  logic [NUM_CH-1:0]     por_dis,
    output logic [NUM_CH-1:0]     drv_low
);
    localparam int unsigned DLY_MAX = rsv_pkg::max4(DLY_SEL0, DLY_SEL1, DLY_SEL2, DLY_SEL3);
    localparam int unsigned CNT_W   = $clog2(DLY_MAX + 1);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        rsv_channel #(
            .DLY_SEL0 (DLY_SEL0),
            .DLY_SEL1 (DLY_SEL1),
            .DLY_SEL2 (DLY_SEL2),
            .DLY_SEL3 (DLY_SEL3),
            .CNT_W    (CNT_W)
        ) ch_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_1us   (tick_1us),
            .en         (en[c]),
            .above_rise (above_rise[c]),
            .below_fall (below_fall[c]),
            .dly_sel    (dly_sel[2*c+1 -: 2]),
            .por_dis    (por_dis[c]),
            .drv_low    (drv_low[c])
        );
    end

endmodule

// File: rtl/rsv_supervisor_chk.sv
module rsv_supervisor_chk #(
    parameter int unsigned NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1us,
    input logic [NUM_CH-1:0] en,
    input logic [NUM_CH-1:0] below_fall,
    input logic [NUM_CH-1:0] por_dis,
    input logic [NUM_CH-1:0] drv_low
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R8: supervision-off releases the line in the same cycle
        assert_dis_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
            por_dis[c] |-> !drv_low[c]);

        // R6: fault pulls the line low on the next edge
        assert_fault_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
            below_fall[c] |=> (drv_low[c] || por_dis[c]));

        // R7: enable loss pulls the line low on the next edge
        assert_en_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !en[c] |=> (drv_low[c] || por_dis[c]));

        // R3: a release only follows a counted tick on an enabled, fault-free channel
        assert_release_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(drv_low[c]) && !drv_low[c] && !por_dis[c])
                |-> $past(tick_1us && en[c] && !below_fall[c]));

        // R10: the line only goes low again for a cause
        assert_low_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(drv_low[c]) |-> ($past(por_dis[c]) || $past(!en[c]) || $past(below_fall[c])));
    end
endmodule

bind rsv_supervisor rsv_supervisor_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_1us   (tick_1us),
    .en         (en),
    .below_fall (below_fall),
    .por_dis    (por_dis),
    .drv_low    (drv_low)
);

// File: tb/rsv_supervisor_tb.sv
module rsv_supervisor_tb_top;
    localparam int unsigned D0 = 6;
    localparam int unsigned D1 = 3;
    localparam int unsigned D2 = 9;
    localparam int unsigned D3 = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1us = 1'b0;
    logic [1:0] en = 2'b00;
    logic [1:0] above_rise = 2'b00;
    logic [1:0] below_fall = 2'b00;
    logic [3:0] dly_sel = 4'b0000;
    logic [1:0] por_dis = 2'b00;
    logic [1:0] drv_low;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rsv_supervisor #(
        .NUM_CH (2), .DLY_SEL0 (D0), .DLY_SEL1 (D1), .DLY_SEL2 (D2), .DLY_SEL3 (D3)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .tick_1us (tick_1us), .en (en),
        .above_rise (above_rise), .below_fall (below_fall), .dly_sel (dly_sel),
        .por_dis (por_dis), .drv_low (drv_low)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1us = 1'b1;
            @(negedge clk);
            tick_1us = 1'b0;
        end
    endtask

    task automatic quiesce();
        en = 2'b00; above_rise = 2'b00; below_fall = 2'b00; por_dis = 2'b00;
        @(negedge clk);
        en = 2'b11;
        @(negedge clk);
    endtask

    task automatic arm(input int ch);
        above_rise[ch] = 1'b1;
        below_fall[ch] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ch0 low after reset", drv_low[0], 1'b1);
        chk("R1 ch1 low after reset", drv_low[1], 1'b1);
    endtask

    task automatic t_no_rise();
        quiesce();
        ticks(20);
        chk("R2 ch0 held without rise", drv_low[0], 1'b1);
        chk("R2 ch1 held without rise", drv_low[1], 1'b1);
    endtask

    task automatic t_sel_codes();
        for (int c = 0; c < 4; c++) begin
            int n;
            n = (c == 0) ? D0 : (c == 1) ? D1 : (c == 2) ? D2 : D3;
            quiesce();
            dly_sel[1:0] = 2'(c);
            arm(0);
            ticks(n - 1);
            chk($sformatf("R3 code %0d low before last tick", c), drv_low[0], 1'b1);
            ticks(1);
            chk($sformatf("R3 code %0d released on last tick", c), drv_low[0], 1'b0);
        end
    endtask

    task automatic t_sel_latch();
        quiesce();
        dly_sel[1:0] = 2'b01;
        arm(0);
        dly_sel[1:0] = 2'b11;
        ticks(D1 - 1);
        chk("R4 low before captured wait ends", drv_low[0], 1'b1);
        ticks(1);
        chk("R4 released at captured wait", drv_low[0], 1'b0);
    endtask

    task automatic t_cancel();
        quiesce();
        dly_sel[1:0] = 2'b00;
        arm(0);
        ticks(D0 - 2);
        below_fall[0] = 1'b1; above_rise[0] = 1'b0;
        @(negedge clk);
        chk("R5 low after cancel", drv_low[0], 1'b1);
        arm(0);
        ticks(D0 - 1);
        chk("R5 full wait restarts", drv_low[0], 1'b1);
        ticks(1);
        chk("R5 released after full wait", drv_low[0], 1'b0);
    endtask

    task automatic t_fault();
        quiesce();
        dly_sel[1:0] = 2'b01;
        arm(0);
        ticks(D1);
        chk("R6 released before fault", drv_low[0], 1'b0);
        below_fall[0] = 1'b1;
        @(negedge clk);
        chk("R6 low one edge after fault", drv_low[0], 1'b1);
    endtask

    task automatic t_enable();
        quiesce();
        dly_sel[1:0] = 2'b01;
        arm(0);
        ticks(D1);
        en[0] = 1'b0;
        @(negedge clk);
        chk("R7 low one edge after enable loss", drv_low[0], 1'b1);
        en[0] = 1'b1;
        @(negedge clk);
        ticks(D1 - 1);
        chk("R7 full wait after enable returns", drv_low[0], 1'b1);
        ticks(1);
        chk("R7 released after full wait", drv_low[0], 1'b0);
    endtask

    task automatic t_disable();
        quiesce();
        dly_sel[1:0] = 2'b01;
        por_dis[0] = 1'b1;
        #1;
        chk("R8 released same cycle when off", drv_low[0], 1'b0);
        below_fall[0] = 1'b1;
        @(negedge clk);
        chk("R8 released despite fault flag", drv_low[0], 1'b0);
        below_fall[0] = 1'b0; above_rise[0] = 1'b1;
        ticks(D1 + 2);
        por_dis[0] = 1'b0;
        #1;
        chk("R8 low once supervision returns", drv_low[0], 1'b1);
        @(negedge clk);
        ticks(D1 - 1);
        chk("R8 full wait after supervision returns", drv_low[0], 1'b1);
        ticks(1);
        chk("R8 released after full wait", drv_low[0], 1'b0);
    endtask

    task automatic t_hyst();
        quiesce();
        dly_sel[1:0] = 2'b01;
        arm(0);
        ticks(1);
        above_rise[0] = 1'b0;
        ticks(D1 - 2);
        chk("R10 wait continues with rise flag low", drv_low[0], 1'b1);
        ticks(1);
        chk("R10 wait completes with rise flag low", drv_low[0], 1'b0);
        ticks(4);
        chk("R10 stays released in band", drv_low[0], 1'b0);
    endtask

    task automatic t_indep();
        quiesce();
        dly_sel = 4'b0101;
        arm(0);
        arm(1);
        ticks(D1 - 1);
        chk("R9 ch1 still waiting", drv_low[1], 1'b1);
        ticks(1);
        chk("R9 ch0 released", drv_low[0], 1'b0);
        below_fall[1] = 1'b1;
        dly_sel[3:2] = 2'b11;
        @(negedge clk);
        chk("R9 ch1 low on its fault", drv_low[1], 1'b1);
        chk("R9 ch0 unaffected by ch1 fault", drv_low[0], 1'b0);
        en[1] = 1'b0;
        @(negedge clk);
        chk("R9 ch0 unaffected by ch1 enable", drv_low[0], 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_rise();
        t_sel_codes();
        t_sel_latch();
        t_cancel();
        t_fault();
        t_enable();
        t_disable();
        t_hyst();
        t_indep();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule